// File: doc/BRIEF.md
# Host I/O Port Decoder with Auto-Incrementing Word Address

This block sits between a 16-bit host I/O bus and the resources of an interface card. It claims a block of eight I/O addresses. Address bit 9 must be one, and bits 8..3 must equal a six-bit base value taken from switches. The default switch setting places the block at 02A0h, which puts the four ports at 02A0h, 02A2h, 02A4h and 02A6h. Inside the block, four even offsets select four ports:

- a write-only word-address register;
- a shared word memory;
- the internal register file of a protocol controller;
- a card status register on reads, which is a control register on writes.

The word-address register is shared by the memory port and the controller-register port. Each completed access through either of those ports advances it by one. This lets the host stream a block of consecutive words after writing a single start address. The memory array, the controller and the status/control logic are outside this block. The block only decodes, addresses and multiplexes read data. Host strobes are treated as levels sampled on the block clock.

Top module: `hpio_decoder`

## Requirements
- R1: The block matches (`xcvr_en` = 1) exactly when all of these hold: `io_addr[9]` = 1, `io_addr[8:3]` equals `base_sw`, `io_addr[0]` = 0, and `dma_busy` = 0. While `dma_busy` is high nothing is decoded.
- R2: On a match with `io_rd` or `io_wr` high, `io_addr[2:1]` picks the port: 00 is the address register, 01 is memory (`mem_sel`), 10 is controller registers (`creg_sel`), 11 is status/control (`stat_sel`). At most one select is high at a time, and no select is high without a strobe.
- R3: A matched write at offset 0 loads `word_addr` from `io_wdata[15:0]`. The new value is visible one clock after the strobe is first sampled.
- R4: When a matched memory or controller-register access ends (its strobe falls), `word_addr` increases by exactly one. The increment is visible one clock after the strobe is sampled low. During the access `word_addr` holds the pre-increment value, and a strobe held for several cycles still gives a single increment.
- R5: Incrementing `word_addr` from FFFFh gives 0000h.
- R6: `word_addr` is unchanged by status/control accesses, by reads of offset 0, by unmatched addresses, and by any strobe issued while `dma_busy` is high.
- R7: `io_rdata` equals `mem_rdata`, `creg_rdata` or `stat_rdata` for a matched read at offset 2, 4 or 6. It is zero for a read at offset 0, and zero whenever there is no matched read.
- R8: `creg_idx` always equals the low five bits of `word_addr`.
- R9: `ctl_wr` is high only during a matched write at offset 6.
- R10: After reset `word_addr` is 0000h and all selects are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 10 | Host I/O address |
| io_wdata | input | 16 | Host write data, bit 0 least significant |
| io_rd | input | 1 | Host read strobe (level) |
| io_wr | input | 1 | Host write strobe (level) |
| dma_busy | input | 1 | High while a DMA transfer is in progress |
| base_sw | input | 6 | Base switch value compared with address bits 8..3 |
| mem_rdata | input | 16 | Read data from the word memory |
| creg_rdata | input | 16 | Read data from the controller register file |
| stat_rdata | input | 16 | Card status word |
| xcvr_en | output | 1 | Data transceiver enable on address match |
| mem_sel | output | 1 | Memory port access in progress |
| creg_sel | output | 1 | Controller-register port access in progress |
| stat_sel | output | 1 | Status/control port access in progress |
| ctl_wr | output | 1 | Control-register write strobe |
| word_addr | output | 16 | Current shared word address |
| creg_idx | output | 5 | Controller register index |
| io_rdata | output | 16 | Read data returned to the host |

## Verification
The decode is tried with addresses at every even offset of the block. These are contrasted with the odd offsets, the next block up, an address with bit 9 clear, a base mismatch in bit 8, and a matching address under DMA. Together they separate the compare on each field from the port decode and from the strobe qualification. The address register is tried as follows:
- loaded, then stepped through mixed memory reads and controller-register writes, with the address checked both during and after each access;
- held against status, address-port and unmatched accesses, which tells the increment condition apart from any strobe;
- given a long strobe to prove a single step per access, and a wrap from FFFFh.

A second base switch value confirms the compare follows the switches.

// File: rtl/hpio_pkg.sv
package hpio_pkg;

   // Port chosen by host address bits 2..1 inside the claimed block
   typedef enum logic [1:0] {
      PORT_ADDR = 2'b00,
      PORT_MEM  = 2'b01,
      PORT_CREG = 2'b10,
      PORT_STAT = 2'b11
   } port_e;

endpackage

// File: rtl/hpio_match.sv
module hpio_match
   import hpio_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int BLK_W  = 3,
   localparam int BASE_W = ADDR_W - 1 - BLK_W
) (
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [BASE_W-1:0] base_sw,
   input  logic              dma_busy,
   output logic              hit,
   output port_e             port
);

   logic [BASE_W-1:0] bit_eq;

   // Per-bit comparison of the block field against the switches
   for (genvar gi = 0; gi < BASE_W; gi++) begin : g_cmp
      assign bit_eq[gi] = (io_addr[BLK_W+gi] == base_sw[gi]);
   end

   // Top address bit fixed at one, word-aligned only, idle during DMA
   assign hit  = io_addr[ADDR_W-1] & (&bit_eq) & ~io_addr[0] & ~dma_busy;
   assign port = port_e'(io_addr[2:1]);

endmodule

// File: rtl/hpio_addr_ctr.sv
module hpio_addr_ctr #(
   parameter int WA_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ld,
   input  logic [WA_W-1:0] ld_val,
   input  logic            acc,
   output logic [WA_W-1:0] word_addr
);

   logic acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q     <= 1'b0;
         word_addr <= '0;
      end else begin
         acc_q <= acc;
         if (ld) begin
            word_addr <= ld_val;
         end else if (acc_q && !acc) begin
            // Access just ended: step once, wrapping at the top
            word_addr <= word_addr + WA_W'(1);
         end
      end
   end

endmodule

// File: rtl/hpio_rd_mux.sv
module hpio_rd_mux
   import hpio_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter bit CLEAR_IDLE = 1'b1
) (
   input  logic              rd_en,
   input  port_e             port,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [DATA_W-1:0] creg_rdata,
   input  logic [DATA_W-1:0] stat_rdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] pick;

   always_comb begin
      unique case (port)
         PORT_MEM:  pick = mem_rdata;
         PORT_CREG: pick = creg_rdata;
         PORT_STAT: pick = stat_rdata;
         default:   pick = '0;
      endcase
   end

   if (CLEAR_IDLE) begin : g_clear
      assign rdata = rd_en ? pick : '0;
   end else begin : g_pass
      logic unused_rd;
      assign unused_rd = rd_en;
      assign rdata     = pick;
   end

endmodule

// File: rtl/hpio_decoder.sv
module hpio_decoder
   import hpio_pkg::*;
#(
   parameter int IO_ADDR_W  = 10,
   parameter int DATA_W     = 16,
   parameter int WA_W       = 16,
   parameter int CREG_IDX_W = 5,
   parameter int BLK_W      = 3,
   localparam int BASE_W    = IO_ADDR_W - 1 - BLK_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [IO_ADDR_W-1:0]  io_addr,
   input  logic [DATA_W-1:0]     io_wdata,
   input  logic                  io_rd,
   input  logic                  io_wr,
   input  logic                  dma_busy,
   input  logic [BASE_W-1:0]     base_sw,
   input  logic [DATA_W-1:0]     mem_rdata,
   input  logic [DATA_W-1:0]     creg_rdata,
   input  logic [DATA_W-1:0]     stat_rdata,
   output logic                  xcvr_en,
   output logic                  mem_sel,
   output logic                  creg_sel,
   output logic                  stat_sel,
   output logic                  ctl_wr,
   output logic [WA_W-1:0]       word_addr,
   output logic [CREG_IDX_W-1:0] creg_idx,
   output logic [DATA_W-1:0]     io_rdata
);

   // Elaboration-time parameter checks
   if (BLK_W != 3) begin : g_bad_blk
      $error("hpio_decoder: block must span eight addresses");
   end
   if (WA_W > DATA_W) begin : g_bad_wa
      $error("hpio_decoder: word address wider than data bus");
   end
   if (CREG_IDX_W > WA_W) begin : g_bad_idx
      $error("hpio_decoder: register index wider than word address");
   end
   if (BASE_W < 1) begin : g_bad_base
      $error("hpio_decoder: host address too narrow");
   end

   logic  hit;
   port_e port;
   logic  strobe;
   logic  addr_ld;
   logic  acc_now;

   hpio_match #(
      .ADDR_W (IO_ADDR_W),
      .BLK_W  (BLK_W)
   ) u_match (
      .io_addr  (io_addr),
      .base_sw  (base_sw),
      .dma_busy (dma_busy),
      .hit      (hit),
      .port     (port)
   );

   assign strobe   = io_rd | io_wr;
   assign xcvr_en  = hit;
   assign mem_sel  = hit & strobe & (port == PORT_MEM);
   assign creg_sel = hit & strobe & (port == PORT_CREG);
   assign stat_sel = hit & strobe & (port == PORT_STAT);
   assign ctl_wr   = stat_sel & io_wr;
   assign addr_ld  = hit & io_wr & (port == PORT_ADDR);
   assign acc_now  = mem_sel | creg_sel;

   // Upper write-data bits beyond the word address are not stored
   if (WA_W < DATA_W) begin : g_wd_spare
      logic unused_wd;
      assign unused_wd = |io_wdata[DATA_W-1:WA_W];
   end

   hpio_addr_ctr #(
      .WA_W (WA_W)
   ) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld        (addr_ld),
      .ld_val    (io_wdata[WA_W-1:0]),
      .acc       (acc_now),
      .word_addr (word_addr)
   );

   assign creg_idx = word_addr[CREG_IDX_W-1:0];

   hpio_rd_mux #(
      .DATA_W     (DATA_W),
      .CLEAR_IDLE (1'b1)
   ) u_rmux (
      .rd_en      (hit & io_rd),
      .port       (port),
      .mem_rdata  (mem_rdata),
      .creg_rdata (creg_rdata),
      .stat_rdata (stat_rdata),
      .rdata      (io_rdata)
   );

endmodule

// File: rtl/hpio_decoder_chk.sv
module hpio_decoder_chk #(
   parameter int DATA_W = 16,
   parameter int WA_W   = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dma_busy,
   input logic              io_rd,
   input logic              io_wr,
   input logic              xcvr_en,
   input logic              mem_sel,
   input logic              creg_sel,
   input logic              stat_sel,
   input logic              ctl_wr,
   input logic [WA_W-1:0]   word_addr,
   input logic [DATA_W-1:0] io_rdata,
   input logic              addr_ld,
   input logic              acc_now
);

   // R2
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_sel, creg_sel, stat_sel}));

   // R1
   sel_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_sel || creg_sel || stat_sel) |-> xcvr_en);

   // R1
   dma_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_busy |-> !xcvr_en);

   // R9
   ctl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |-> (stat_sel && io_wr));

   // R7
   rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !io_rd |-> (io_rdata == '0));

   // R4
   step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((word_addr != $past(word_addr)) && !$past(addr_ld))
         |-> (word_addr == $past(word_addr) + WA_W'(1)));

   // R6
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(addr_ld) && !($past(acc_now, 2) && !$past(acc_now)))
         |-> (word_addr == $past(word_addr)));

endmodule

bind hpio_decoder hpio_decoder_chk #(
   .DATA_W (DATA_W),
   .WA_W   (WA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dma_busy  (dma_busy),
   .io_rd     (io_rd),
   .io_wr     (io_wr),
   .xcvr_en   (xcvr_en),
   .mem_sel   (mem_sel),
   .creg_sel  (creg_sel),
   .stat_sel  (stat_sel),
   .ctl_wr    (ctl_wr),
   .word_addr (word_addr),
   .io_rdata  (io_rdata),
   .addr_ld   (addr_ld),
   .acc_now   (acc_now)
);

// File: tb/hpio_decoder_tb.sv
module hpio_decoder_tb;

   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] MEM_D  = 16'hC0DE;
   localparam logic [15:0] CREG_D = 16'h5EED;
   localparam logic [15:0] STAT_D = 16'h7A7A;

   // Vector: addr[31:22] dma[21] rd[20] {xcvr,mem,creg,stat}[19:16] rdata[15:0]
   localparam int NV = 11;
   localparam logic [31:0] VEC [NV] = '{
      {10'h2A0, 1'b0, 1'b1, 4'b1000, 16'h0000},
      {10'h2A2, 1'b0, 1'b1, 4'b1100, 16'hC0DE},
      {10'h2A4, 1'b0, 1'b1, 4'b1010, 16'h5EED},
      {10'h2A6, 1'b0, 1'b1, 4'b1001, 16'h7A7A},
      {10'h2A8, 1'b0, 1'b1, 4'b0000, 16'h0000},
      {10'h2A3, 1'b0, 1'b1, 4'b0000, 16'h0000},
      {10'h0A0, 1'b0, 1'b1, 4'b0000, 16'h0000},
      {10'h2A2, 1'b1, 1'b1, 4'b0000, 16'h0000},
      {10'h3A2, 1'b0, 1'b1, 4'b0000, 16'h0000},
      {10'h2A2, 1'b0, 1'b0, 4'b1000, 16'h0000},
      {10'h2A7, 1'b0, 1'b1, 4'b0000, 16'h0000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  io_addr = '0;
   logic [15:0] io_wdata = '0;
   logic        io_rd = 1'b0;
   logic        io_wr = 1'b0;
   logic        dma_busy = 1'b0;
   logic [5:0]  base_sw = 6'h14;
   logic        xcvr_en, mem_sel, creg_sel, stat_sel, ctl_wr;
   logic [15:0] word_addr;
   logic [4:0]  creg_idx;
   logic [15:0] io_rdata;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hpio_decoder u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .io_addr    (io_addr),
      .io_wdata   (io_wdata),
      .io_rd      (io_rd),
      .io_wr      (io_wr),
      .dma_busy   (dma_busy),
      .base_sw    (base_sw),
      .mem_rdata  (MEM_D),
      .creg_rdata (CREG_D),
      .stat_rdata (STAT_D),
      .xcvr_en    (xcvr_en),
      .mem_sel    (mem_sel),
      .creg_sel   (creg_sel),
      .stat_sel   (stat_sel),
      .ctl_wr     (ctl_wr),
      .word_addr  (word_addr),
      .creg_idx   (creg_idx),
      .io_rdata   (io_rdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Raise a strobe at a falling edge; it is sampled at the next rising edge
   task automatic start_acc(input logic [9:0] a, input bit wr, input logic [15:0] d);
      @(negedge clk);
      io_addr  = a;
      io_wdata = d;
      io_wr    = wr;
      io_rd    = !wr;
   endtask

   // Drop the strobe; after the next rising edge the step is visible
   task automatic end_acc;
      @(negedge clk);
      io_rd = 1'b0;
      io_wr = 1'b0;
      @(negedge clk);
   endtask

   task automatic load_addr(input logic [15:0] v);
      start_acc(10'h2A0, 1'b1, v);
      end_acc();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 word_addr", 32'(word_addr), 32'h0);
      chk("R10 selects", 32'({mem_sel, creg_sel, stat_sel, ctl_wr}), 32'h0);

      // Table walk: decode and read mux (R1, R2, R7)
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         io_addr  = VEC[i][31:22];
         dma_busy = VEC[i][21];
         io_rd    = VEC[i][20];
         #1;
         chk("R1/R2 decode", 32'({xcvr_en, mem_sel, creg_sel, stat_sel}), 32'(VEC[i][19:16]));
         chk("R7 rdata", 32'(io_rdata), 32'(VEC[i][15:0]));
         @(negedge clk);
         io_rd    = 1'b0;
         dma_busy = 1'b0;
         @(negedge clk);
      end

      // R3 load
      load_addr(16'h1234);
      chk("R3 load", 32'(word_addr), 32'h1234);

      // R4 memory read uses old address, then steps
      start_acc(10'h2A2, 1'b0, 16'h0);
      #1;
      chk("R4 pre-increment", 32'(word_addr), 32'h1234);
      end_acc();
      chk("R4 step after mem", 32'(word_addr), 32'h1235);

      // R8 / R4 controller register write
      start_acc(10'h2A4, 1'b1, 16'hBEEF);
      #1;
      chk("R8 creg_idx", 32'(creg_idx), 32'h15);
      chk("R2 creg_sel", 32'(creg_sel), 32'h1);
      end_acc();
      chk("R4 step after creg", 32'(word_addr), 32'h1236);

      // R9 / R6 control write
      start_acc(10'h2A6, 1'b1, 16'h0001);
      #1;
      chk("R9 ctl_wr on write", 32'(ctl_wr), 32'h1);
      end_acc();
      chk("R6 stat write hold", 32'(word_addr), 32'h1236);

      start_acc(10'h2A6, 1'b0, 16'h0);
      #1;
      chk("R9 ctl_wr on read", 32'(ctl_wr), 32'h0);
      end_acc();

      // R6 address-port read, miss, DMA
      start_acc(10'h2A0, 1'b0, 16'h0);
      end_acc();
      chk("R6 addr read hold", 32'(word_addr), 32'h1236);
      start_acc(10'h2AA, 1'b0, 16'h0);
      end_acc();
      chk("R6 miss hold", 32'(word_addr), 32'h1236);
      @(negedge clk);
      dma_busy = 1'b1;
      start_acc(10'h2A2, 1'b0, 16'h0);
      #1;
      chk("R1 dma xcvr", 32'(xcvr_en), 32'h0);
      end_acc();
      dma_busy = 1'b0;
      chk("R6 dma hold", 32'(word_addr), 32'h1236);

      // R4 long strobe steps once
      load_addr(16'h0040);
      start_acc(10'h2A2, 1'b0, 16'h0);
      repeat (3) @(negedge clk);
      end_acc();
      chk("R4 single step", 32'(word_addr), 32'h0041);

      // R5 wrap
      load_addr(16'hFFFF);
      start_acc(10'h2A4, 1'b0, 16'h0);
      end_acc();
      chk("R5 wrap", 32'(word_addr), 32'h0000);

      // R1 other base value
      @(negedge clk);
      base_sw = 6'h3F;
      start_acc(10'h3FA, 1'b0, 16'h0);
      #1;
      chk("R1 base 3F mem_sel", 32'(mem_sel), 32'h1);
      chk("R7 base 3F rdata", 32'(io_rdata), 32'(MEM_D));
      end_acc();
      chk("R4 base 3F step", 32'(word_addr), 32'h0001);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule